// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven station-management master. It builds serial management frames toward external PHY devices on a divided management clock (MDC) and a bidirectional data line (MDIO). The data line is presented as an output, an output enable and an input. Software uses a small 32-bit register bus with two word registers. It loads the data register first, then writes the control register with the busy bit set. That second write starts one transaction, and the busy bit stays at 1 until the transaction has ended.

A parameter picks one of two control layouts. The legacy layout issues Clause 22 accesses only, and one bit chooses write or read. The extended layout has a two-bit operation field and a Clause 45 enable. With Clause 45 set, the register field carries the MMD device number and the upper half of the data register carries the 16-bit register number. One start then sends an address frame, followed at once by the operation frame. Read results land in the low half of the data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The control register is at word address 0 and the data register at word address 1. A read strobe returns the selected register on bus_rdata one cycle later. Control bit 0 is busy: writing it as 1 launches a transaction, and it reads back 1 until every frame of that transaction has finished and 0 afterwards.
- R2: In legacy mode, control bit 1 selects write (1) or read (0). The frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register, turnaround 10, then 16 data bits, all sent MSB first. Control bits 3:2 have no effect in this mode.
- R3: In extended mode, control bits 3:2 select the command: 01 sends a write and 11 sends a read. With bit 1 clear, the frames are Clause 22 frames as in R2.
- R4: In extended mode with control bit 1 set, one start sends an address frame followed by an operation frame. The address frame is 32 ones, start 00, opcode 00, PHY, device, turnaround 10, and data register bits 31:16. The operation frame uses start 00, opcode 01 (write, data bits 15:0) or opcode 11 (read).
- R5: In a read frame, MDIO output enable drops from the turnaround onward, so only the first 46 bits are driven. The 16 bits sampled from mdio_i land in data register bits 15:0, and bits 31:16 stay unchanged.
- R6: Control fields: PHY address in bits 25:21, register or device address in bits 20:16, clock range in bits 11:8. Unused bits read 0.
- R7: The MDC period in host cycles is 16, 26, 42 or 62 for range codes 0, 1, 2 and 3, and 62 for every other code. MDC is high for half the period and rests low when idle.
- R8: MDIO changes only while MDC is low, at the falling edge. It holds its value while MDC is high, and mdio_i is sampled at the rising edge.
- R9: Bus writes to either register while busy is 1 are ignored. They change no field and start no extra frame.
- R10: After reset both registers read 0, and MDC and the MDIO output enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit index or shift register corrupts the bit sequence that the bench collects on each MDC rising edge. The bench catches this at the end of the affected 64-bit frame, and it also catches a missing or extra second frame in Clause 45 mode. A wrong divider choice shows up as a wrong MDC period on the first full cycle. A wrong capture window or release point shows up as a wrong data register value, or a wrong output-enable pattern, on the read that follows. A broken busy or write gate lets a mid-transaction write alter the readback, or launch a frame that has no matching expectation.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int HALF_W     = 5;
  localparam int CR_W       = 4;
  localparam int FLD_W      = 5;
  localparam int OP_LO      = 2;
  localparam int CR_LO      = 8;
  localparam int REG_LO     = 16;
  localparam int PHY_LO     = 21;

  function automatic logic [HALF_W-1:0] half_of(input logic [CR_W-1:0] code);
    case (code)
      4'd0:    half_of = 5'd8;
      4'd1:    half_of = 5'd13;
      4'd2:    half_of = 5'd21;
      default: half_of = 5'd31;
    endcase
  endfunction

  function automatic logic [FRAME_BITS-1:0] mk_frame(
      input logic [1:0] st, input logic [1:0] op,
      input logic [FLD_W-1:0] pa, input logic [FLD_W-1:0] ra,
      input logic [15:0] d, input logic rd);
    mk_frame = {32'hFFFF_FFFF, st, op, pa, ra,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign tick = run && (cnt == half - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  two,
  input  logic [FRAME_BITS-1:0] fa,
  input  logic [FRAME_BITS-1:0] fb,
  input  logic                  b_rd,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mdio_i,
  output logic                  run,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx, nidx;
  logic                  cur_rd, pend_b;

  assign nidx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0; done <= 1'b0;
      rdata <= '0; sh <= '0; idx <= '0; cur_rd <= 1'b0; pend_b <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          idx     <= '0;
          mdio_oe <= 1'b1;
          pend_b  <= two;
          sh      <= two ? fa : fb;
          cur_rd  <= two ? 1'b0 : b_rd;
          mdio_o  <= two ? fa[FRAME_BITS-1] : fb[FRAME_BITS-1];
        end
      end else begin
        if (rise && cur_rd && idx >= RD_IDX)
          rdata <= {rdata[14:0], mdio_i};
        if (fall) begin
          if (idx == LAST_IDX) begin
            if (pend_b) begin
              pend_b  <= 1'b0;
              sh      <= fb;
              idx     <= '0;
              cur_rd  <= b_rd;
              mdio_o  <= fb[FRAME_BITS-1];
              mdio_oe <= 1'b1;
            end else begin
              run     <= 1'b0;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              done    <= 1'b1;
            end
          end else begin
            sh      <= sh << 1;
            idx     <= nidx;
            mdio_o  <= sh[FRAME_BITS-2];
            mdio_oe <= !(cur_rd && nidx >= TA_IDX);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter bit EXT_MODE = 1'b1,
  parameter int CTRL_OFS = 0,
  parameter int DATA_OFS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             busy_q, b1_q, start_q;
  logic [1:0]       op_q;
  logic [CR_W-1:0]  cr_q;
  logic [FLD_W-1:0] phy_q, rad_q;
  logic [31:0]      data_q, ctrl_word;
  logic             wr_ctrl, wr_data, is_rd, is_c45;
  logic             run, rise, fall, done;
  logic [15:0]      rd_val;
  logic [FRAME_BITS-1:0] frame_a, frame_b;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:26], bus_wdata[15:12], bus_wdata[7:4]};

  assign wr_ctrl = bus_wr && !busy_q && (bus_addr == ADDR_W'(CTRL_OFS));
  assign wr_data = bus_wr && !busy_q && (bus_addr == ADDR_W'(DATA_OFS));

  generate
    if (EXT_MODE) begin : g_ext
      assign is_c45 = b1_q;
      assign is_rd  = (op_q == 2'b11);
    end else begin : g_leg
      assign is_c45 = 1'b0;
      assign is_rd  = !b1_q;
    end
  endgenerate

  always_comb begin
    frame_a = mk_frame(2'b00, 2'b00, phy_q, rad_q, data_q[31:16], 1'b0);
    if (is_c45)
      frame_b = mk_frame(2'b00, is_rd ? 2'b11 : 2'b01, phy_q, rad_q, data_q[15:0], is_rd);
    else
      frame_b = mk_frame(2'b01, is_rd ? 2'b10 : 2'b01, phy_q, rad_q, data_q[15:0], is_rd);
  end

  assign ctrl_word = {6'd0, phy_q, rad_q, 4'd0, cr_q, 4'd0, op_q, b1_q, busy_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; b1_q <= 1'b0; start_q <= 1'b0; op_q <= '0;
      cr_q <= '0; phy_q <= '0; rad_q <= '0; data_q <= '0; bus_rdata <= '0;
    end else begin
      start_q <= 1'b0;
      if (wr_data) data_q <= bus_wdata;
      if (wr_ctrl) begin
        busy_q  <= bus_wdata[0];
        start_q <= bus_wdata[0];
        b1_q    <= bus_wdata[1];
        op_q    <= bus_wdata[OP_LO +: 2];
        cr_q    <= bus_wdata[CR_LO +: CR_W];
        rad_q   <= bus_wdata[REG_LO +: FLD_W];
        phy_q   <= bus_wdata[PHY_LO +: FLD_W];
      end
      if (done) begin
        busy_q <= 1'b0;
        if (is_rd) data_q[15:0] <= rd_val;
      end
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(CTRL_OFS))      bus_rdata <= ctrl_word;
        else if (bus_addr == ADDR_W'(DATA_OFS)) bus_rdata <= data_q;
        else                                    bus_rdata <= '0;
      end
    end
  end

  mdio_clk_div u_div (
    .clk(clk), .rst(rst), .run(run), .half(half_of(cr_q)),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(start_q), .two(is_c45),
    .fa(frame_a), .fb(frame_b), .b_rd(is_rd), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rdata(rd_val)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [4:0] phy,
  input logic [3:0] cr
);
  // R1: with no transaction pending the line is released and MDC rests low
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));

  // R8: data moves only while MDC is low
  p_mdio_moves_low_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  // R5: the line is already released when busy drops
  p_release_first_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !mdio_oe);

  // R9: fields hold while a transaction runs
  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(phy) && $stable(cr)));

  // R7: MDC toggles only inside a transaction
  p_mdc_in_txn_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .phy(phy_q), .cr(cr_q)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, sel = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata0, rdata1, rdata_m;
  logic mdc0, mdc1, mo0, mo1, oe0, oe1, mdc_m, mo_m, oe_m;
  logic mdio_i = 1'b1;
  logic [15:0] rdval = '0;

  int total = 0, bad = 0, cyc = 0, nb = 0, period = 0, last_rise = 0, r8_err = 0;
  bit finished = 0;
  logic held = 1'b0;
  logic [63:0] got = '0, goe = '0;
  logic [63:0] q_frame[$];
  int q_n[$];
  string q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_mgmt_master #(.EXT_MODE(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr && !sel), .bus_rd(bus_rd && !sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .mdc(mdc0), .mdio_o(mo0), .mdio_oe(oe0), .mdio_i(mdio_i));

  mdio_mgmt_master #(.EXT_MODE(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr && sel), .bus_rd(bus_rd && sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .mdc(mdc1), .mdio_o(mo1), .mdio_oe(oe1), .mdio_i(mdio_i));

  assign mdc_m   = sel ? mdc1 : mdc0;
  assign mo_m    = sel ? mo1 : mo0;
  assign oe_m    = sel ? oe1 : oe0;
  assign rdata_m = sel ? rdata1 : rdata0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bf(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] cw(input logic [4:0] pa, input logic [4:0] ra,
      input logic [3:0] cr, input logic [1:0] op, input logic b1, input logic busy);
    return {6'd0, pa, ra, 4'd0, cr, 4'd0, op, b1, busy};
  endfunction

  // driver side of the scoreboard
  task automatic push(input logic [63:0] f, input int n, input string tag);
    q_frame.push_back(f); q_n.push_back(n); q_tag.push_back(tag);
  endtask

  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = rdata_m;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      brd(2'd0, v);
      if (!v[0]) return;
    end
  endtask

  // monitor side: the frame bits seen at each MDC rising edge
  always @(posedge mdc_m) begin
    got = {got[62:0], mo_m};
    goe = {goe[62:0], oe_m};
    nb++;
    period = cyc - last_rise;
    last_rise = cyc;
    if (nb == 64) begin
      nb = 0;
      if (q_frame.size() == 0) begin
        chk(1'b0, "R9 frame with no expectation", got, 64'h0);
      end else begin
        logic [63:0] f, m;
        int n;
        string t;
        f = q_frame.pop_front(); n = q_n.pop_front(); t = q_tag.pop_front();
        m = ~64'h0 << (64 - n);
        chk((got & m) == (f & m), {t, " frame bits"}, got & m, f & m);
        chk(goe == m, {t, " output enable"}, goe, m);
      end
    end
  end

  // PHY model: drives read data after each falling MDC edge
  always @(negedge mdc_m) begin
    if (nb >= 48 && nb <= 63) mdio_i = rdval[63 - nb];
    else mdio_i = 1'b1;
  end

  // R8: MDIO must hold while MDC is high
  always @(negedge clk) begin
    if (mdc_m) begin
      if (mo_m !== held) r8_err++;
    end else begin
      held = mo_m;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state on both variants
    brd(2'd0, v); chk(v == 0, "R10 ctrl after reset", v, 0);
    brd(2'd1, v); chk(v == 0, "R10 data after reset", v, 0);
    chk(!mdc0 && !oe0 && !mdc1 && !oe1, "R10 mdc/oe after reset", {mdc0, oe0, mdc1, oe1}, 0);

    // R3 extended Clause 22 write, range 0; R9 writes while busy
    bwr(2'd1, 32'h0000_A5C3);
    push(bf(2'b01, 2'b01, 5'd5, 5'h12, 16'hA5C3), 64, "R3 c22 write");
    bwr(2'd0, cw(5'd5, 5'h12, 4'd0, 2'b01, 1'b0, 1'b1));
    brd(2'd0, v); chk(v[0] == 1'b1, "R1 busy after start", v, 1);
    bwr(2'd1, 32'hFFFF_FFFF);
    bwr(2'd0, cw(5'd9, 5'd1, 4'd3, 2'b11, 1'b1, 1'b1));
    wait_idle();
    chk(q_frame.size() == 0, "R9 no extra frame", q_frame.size(), 0);
    brd(2'd1, v); chk(v == 32'h0000_A5C3, "R9 data kept", v, 32'h0000_A5C3);
    brd(2'd0, v); chk(v == cw(5'd5, 5'h12, 4'd0, 2'b01, 1'b0, 1'b0), "R6 R1 ctrl readback idle", v,
                      cw(5'd5, 5'h12, 4'd0, 2'b01, 1'b0, 1'b0));
    chk(period == 16, "R7 period code 0", period, 16);

    // R5 extended Clause 22 read, range 1
    rdval = 16'h3C96;
    bwr(2'd1, 32'h0000_0000);
    push(bf(2'b01, 2'b10, 5'd1, 5'd2, 16'h0), 46, "R3 c22 read");
    bwr(2'd0, cw(5'd1, 5'd2, 4'd1, 2'b11, 1'b0, 1'b1));
    wait_idle();
    brd(2'd1, v); chk(v == 32'h0000_3C96, "R5 read result", v, 32'h0000_3C96);
    chk(period == 26, "R7 period code 1", period, 26);

    // R4 Clause 45 write
    bwr(2'd1, 32'h1234_BEEF);
    push(bf(2'b00, 2'b00, 5'd3, 5'd7, 16'h1234), 64, "R4 c45 address");
    push(bf(2'b00, 2'b01, 5'd3, 5'd7, 16'hBEEF), 64, "R4 c45 write");
    bwr(2'd0, cw(5'd3, 5'd7, 4'd0, 2'b01, 1'b1, 1'b1));
    wait_idle();
    chk(q_frame.size() == 0, "R4 both frames sent", q_frame.size(), 0);

    // R4 R5 Clause 45 read, range 2
    rdval = 16'h5A0F;
    bwr(2'd1, 32'h0042_0000);
    push(bf(2'b00, 2'b00, 5'h1F, 5'h1E, 16'h0042), 64, "R4 c45 address");
    push(bf(2'b00, 2'b11, 5'h1F, 5'h1E, 16'h0), 46, "R4 c45 read");
    bwr(2'd0, cw(5'h1F, 5'h1E, 4'd2, 2'b11, 1'b1, 1'b1));
    wait_idle();
    brd(2'd1, v); chk(v == 32'h0042_5A0F, "R5 c45 read result", v, 32'h0042_5A0F);
    chk(period == 42, "R7 period code 2", period, 42);

    // R2 legacy write, op bits 11 must not matter, range 3
    @(negedge clk) sel = 1'b1;
    bwr(2'd1, 32'h0000_1357);
    push(bf(2'b01, 2'b01, 5'd4, 5'd6, 16'h1357), 64, "R2 legacy write");
    bwr(2'd0, cw(5'd4, 5'd6, 4'd3, 2'b11, 1'b1, 1'b1));
    wait_idle();
    chk(period == 62, "R7 period code 3", period, 62);

    // R2 legacy read, op bits 01 must not matter, range 9
    rdval = 16'hC0DE;
    push(bf(2'b01, 2'b10, 5'd2, 5'h0B, 16'h0), 46, "R2 legacy read");
    bwr(2'd0, cw(5'd2, 5'h0B, 4'd9, 2'b01, 1'b0, 1'b1));
    wait_idle();
    brd(2'd1, v); chk(v == 32'h0000_C0DE, "R2 legacy read result", v, 32'h0000_C0DE);
    chk(period == 62, "R7 period code 9", period, 62);

    chk(q_frame.size() == 0, "R1 all frames done", q_frame.size(), 0);
    chk(r8_err == 0, "R8 mdio held while mdc high", r8_err, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule